// File: doc/BRIEF.md
# Dual-Bank Packet Transmit Buffer Controller

This block sits between a host and a network transmitter and manages the byte memory that holds outgoing frames. The host loads frames through a write-only data port. Each frame is placed behind a two-byte length header that is never transmitted. The host then writes a control byte that carries a frame count and a start flag. An accepted start hands the loaded bank to the transmitter. In the two-bank layouts, the host can load the other bank while the first one is being sent.

The transmit sequencer works through the bank one frame at a time. For each frame it reads the header, streams the stored bytes on a valid/ready interface, and marks the final byte with a last flag. A collision abandons the frame. After an external backoff-done pulse, the frame is replayed from its first stored byte. When the collision limit is reached, the frame is dropped instead. Once the counted frames are handled, the block returns to idle, sets a done status and, if enabled, raises an interrupt.

The sequencer states are:

| State | Meaning |
|---|---|
| IDLE | Waiting for a start. |
| HDR_LO | Latch length bits 7:0. |
| HDR_HI | Latch length bits 10:8. |
| SEND | Stream bytes. |
| BACKOFF | Wait for the backoff-done pulse. |
| ADVANCE | Step to the next header and decrement the count. |
| DONE | Post the status. |

The transitions are:

- IDLE to HDR_LO on an accepted start.
- HDR_LO to HDR_HI always.
- HDR_HI to SEND, or to ADVANCE when the length is zero.
- SEND to BACKOFF on a collision below the limit.
- SEND to ADVANCE on the last accepted byte, or on the collision that reaches the limit.
- BACKOFF to SEND on backoff-done.
- ADVANCE to HDR_LO while frames remain, otherwise to DONE.
- DONE to IDLE.

Top module: `pktbuf_tx_ctrl`

## Requirements
- R1: After reset, `host_busy`, `tx_valid`, `stat_done`, `stat_excess` and `irq` are all 0, and the host write position is offset 0 of bank 0.
- R2: Each accepted host write stores one byte at the next offset of the loading bank and advances the write offset by one. The offset never decreases except when an accepted start resets it to 0. Writes at or beyond the end of the bank are dropped and do not wrap.
- R3: The `cfg_size` encoding is: 0 gives one bank of UNIT bytes; 1, 2 and 3 give two banks of UNIT, 2*UNIT and 4*UNIT bytes. Bank 1 starts at the bank size. Header and byte offsets wrap within the bank.
- R4: The control byte has the start flag in bit 7 and the frame count in bits 6:0. It is accepted only when the block is idle, bit 7 is 1 and the count is nonzero. Any other control write has no effect.
- R5: In the two-bank modes, an accepted start gives the loaded bank to the transmitter and moves host loading to the other bank at offset 0. Host writes made during the transmission do not alter the bytes sent.
- R6: In single-bank mode, host writes are refused while `host_busy` is 1. `host_busy` is 1 from the cycle after an accepted start until the chain is finished.
- R7: A header is two bytes, low byte first. Length bits 7:0 are in byte 0 and bits 10:8 are in byte 1 bits 2:0; byte 1 bits 7:3 are ignored. Headers are never sent, and a zero length skips the frame.
- R8: Each frame sends exactly its length bytes in stored order. `tx_data` and `tx_last` stay stable while `tx_valid` is 1 and `tx_ready` is 0. `tx_last` is 1 only on the final byte. The next header sits at header offset + 2 + length.
- R9: `tx_collision` during SEND abandons the frame. The block waits for `backoff_done` and then resends the frame from its first byte.
- R10: On the MAX_TRIES-th (default 16) collision of one frame, `stat_excess` is set, the frame is skipped without a backoff wait, and the chain continues.
- R11: When the count is exhausted, the block returns to idle with `stat_done` set and `irq` = `stat_done` AND `irq_en`. Both status flags are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Bank layout select (static while in use) |
| irq_en | input | 1 | Interrupt enable |
| host_wr_en | input | 1 | Host data write strobe |
| host_wr_data | input | 8 | Host data byte |
| host_ctl_wr | input | 1 | Control byte write strobe |
| host_ctl_data | input | 8 | Control byte: bit 7 start, bits 6:0 frame count |
| host_busy | output | 1 | Transmit chain in progress |
| tx_valid | output | 1 | Byte available to the transmitter |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the current frame |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_collision | input | 1 | Collision on the current frame |
| backoff_done | input | 1 | Backoff interval elapsed |
| stat_done | output | 1 | Chain finished |
| stat_excess | output | 1 | A frame hit the collision limit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take several things for granted about the inputs:
- `cfg_size` changes only while the block is idle, and only across a reset.
- A data write and a control write never fall in the same cycle.
- `tx_ready` and `tx_collision` are never raised together.
- `backoff_done` arrives only while a collided frame is waiting.

The stimulus respects all of these. It drives each input from one sequential thread on the falling edge and resets between layout changes. It raises a collision only on a cycle when it withholds ready, and it pulses backoff-done a fixed three cycles after each collision below the limit.

// File: rtl/pktbuf_tx_pkg.sv
package pktbuf_tx_pkg;

    localparam int LEN_W = 11;
    localparam int CNT_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_LO,
        ST_HDR_HI,
        ST_SEND,
        ST_BACKOFF,
        ST_ADVANCE,
        ST_DONE
    } tx_state_e;

    // Bank size is UNIT << bank_shift(cfg_size)
    function automatic int unsigned bank_shift(input logic [1:0] sz);
        case (sz)
            2'd3:    return 2;
            2'd2:    return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pktbuf_mem.sv
module pktbuf_mem #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/pktbuf_host_port.sv
module pktbuf_host_port
    import pktbuf_tx_pkg::*;
#(
    parameter int AW   = 10,
    parameter int UNIT = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_size,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          start_acc,
    input  logic          tx_busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          host_bank
);

    logic          dual;
    logic [AW-1:0] bank_bytes;
    logic [AW-1:0] base;
    logic [AW-1:0] wptr;

    always_comb begin
        dual       = (cfg_size != 2'd0);
        bank_bytes = AW'(UNIT) << bank_shift(cfg_size);
        base       = (dual && host_bank) ? bank_bytes : '0;
        mem_we     = wr_en && !(!dual && tx_busy) && (wptr < bank_bytes);
        mem_waddr  = base + wptr;
        mem_wdata  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr      <= '0;
            host_bank <= 1'b0;
        end else if (start_acc) begin
            wptr <= '0;
            if (dual) begin
                host_bank <= ~host_bank;
            end
        end else if (mem_we) begin
            wptr <= wptr + AW'(1);
        end
    end

    AST_WPTR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !start_acc |=> wptr >= $past(wptr)); // R2

endmodule

// File: rtl/pktbuf_tx_seq.sv
module pktbuf_tx_seq
    import pktbuf_tx_pkg::*;
#(
    parameter int AW        = 10,
    parameter int UNIT      = 128,
    parameter int MAX_TRIES = 16,
    localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_size,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_data,
    input  logic          host_bank,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          tx_collision,
    input  logic          backoff_done,
    output logic          start_acc,
    output logic          busy,
    output logic          tx_bank,
    output logic          stat_done,
    output logic          stat_excess
);

    tx_state_e         state, state_nx;
    logic [AW-1:0]     hdr_off;
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  idx;
    logic [CNT_W-1:0]  pkt_left;
    logic [TRY_W-1:0]  tries;

    logic              dual;
    logic [AW-1:0]     bank_bytes, bank_mask, tx_base;
    logic [AW-1:0]     off_sum, off_adv;
    logic              hit_cap, beat;

    // bank geometry and read address
    always_comb begin
        dual       = (cfg_size != 2'd0);
        bank_bytes = AW'(UNIT) << bank_shift(cfg_size);
        bank_mask  = bank_bytes - AW'(1);
        tx_base    = (dual && tx_bank) ? bank_bytes : '0;
        off_sum    = hdr_off;
        unique case (state)
            ST_HDR_HI: off_sum = hdr_off + AW'(1);
            ST_SEND:   off_sum = hdr_off + AW'(idx) + AW'(2);
            default:   off_sum = hdr_off;
        endcase
        rd_addr = tx_base + (off_sum & bank_mask);
        off_adv = (hdr_off + AW'(len) + AW'(2)) & bank_mask;
    end

    // outputs
    always_comb begin
        start_acc = (state == ST_IDLE) && ctl_wr && ctl_data[7] && (ctl_data[6:0] != '0);
        busy      = (state != ST_IDLE);
        tx_valid  = (state == ST_SEND);
        tx_data   = rd_data;
        tx_last   = tx_valid && (idx == len - LEN_W'(1));
        hit_cap   = (tries == TRY_W'(MAX_TRIES - 1));
        beat      = tx_valid && tx_ready && !tx_collision;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_acc) state_nx = ST_HDR_LO;
            ST_HDR_LO:  state_nx = ST_HDR_HI;
            ST_HDR_HI:  state_nx = ({rd_data[2:0], len[7:0]} == '0) ? ST_ADVANCE : ST_SEND;
            ST_SEND: begin
                if (tx_collision) begin
                    state_nx = hit_cap ? ST_ADVANCE : ST_BACKOFF;
                end else if (beat && tx_last) begin
                    state_nx = ST_ADVANCE;
                end
            end
            ST_BACKOFF: if (backoff_done) state_nx = ST_SEND;
            ST_ADVANCE: state_nx = (pkt_left == CNT_W'(1)) ? ST_DONE : ST_HDR_LO;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tx_bank     <= 1'b0;
            hdr_off     <= '0;
            len         <= '0;
            idx         <= '0;
            pkt_left    <= '0;
            tries       <= '0;
            stat_done   <= 1'b0;
            stat_excess <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (start_acc) begin
                        tx_bank     <= host_bank;
                        hdr_off     <= '0;
                        pkt_left    <= ctl_data[6:0];
                        tries       <= '0;
                        stat_done   <= 1'b0;
                        stat_excess <= 1'b0;
                    end
                end
                ST_HDR_LO: len <= {3'b000, rd_data};
                ST_HDR_HI: begin
                    len[10:8] <= rd_data[2:0];
                    idx       <= '0;
                end
                ST_SEND: begin
                    if (tx_collision) begin
                        idx   <= '0;
                        tries <= tries + TRY_W'(1);
                        if (hit_cap) stat_excess <= 1'b1;
                    end else if (beat) begin
                        idx <= idx + LEN_W'(1);
                    end
                end
                ST_ADVANCE: begin
                    hdr_off  <= off_adv;
                    pkt_left <= pkt_left - CNT_W'(1);
                    tries    <= '0;
                end
                ST_DONE: stat_done <= 1'b1;
                default: ;
            endcase
        end
    end

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !tx_collision |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R8
    AST_RESEND_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACKOFF) && backoff_done |=> tx_valid && (idx == '0)); // R9
    AST_EXCESS_NEEDS_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_excess) |-> $past(tx_collision)); // R10
    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> !busy); // R11

endmodule

// File: rtl/pktbuf_tx_ctrl.sv
module pktbuf_tx_ctrl
    import pktbuf_tx_pkg::*;
#(
    parameter int UNIT      = 128,
    parameter int MAX_TRIES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_size,
    input  logic       irq_en,
    input  logic       host_wr_en,
    input  logic [7:0] host_wr_data,
    input  logic       host_ctl_wr,
    input  logic [7:0] host_ctl_data,
    output logic       host_busy,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    input  logic       tx_ready,
    input  logic       tx_collision,
    input  logic       backoff_done,
    output logic       stat_done,
    output logic       stat_excess,
    output logic       irq
);

    localparam int DEPTH = 8 * UNIT;
    localparam int AW    = $clog2(DEPTH);

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          start_acc, host_bank, tx_bank;

    pktbuf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    pktbuf_host_port #(.AW(AW), .UNIT(UNIT)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_size  (cfg_size),
        .wr_en     (host_wr_en),
        .wr_data   (host_wr_data),
        .start_acc (start_acc),
        .tx_busy   (host_busy),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .host_bank (host_bank)
    );

    pktbuf_tx_seq #(.AW(AW), .UNIT(UNIT), .MAX_TRIES(MAX_TRIES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_size     (cfg_size),
        .ctl_wr       (host_ctl_wr),
        .ctl_data     (host_ctl_data),
        .host_bank    (host_bank),
        .rd_addr      (mem_raddr),
        .rd_data      (mem_rdata),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .tx_collision (tx_collision),
        .backoff_done (backoff_done),
        .start_acc    (start_acc),
        .busy         (host_busy),
        .tx_bank      (tx_bank),
        .stat_done    (stat_done),
        .stat_excess  (stat_excess)
    );

    assign irq = stat_done && irq_en;

    AST_TX_BANK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy && mem_we |-> (cfg_size != 2'd0) && (host_bank != tx_bank)); // R6
    AST_IRQ_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_done); // R11

endmodule

// File: tb/pktbuf_tx_ctrl_test.sv
`timescale 1ns/1ps
module pktbuf_tx_ctrl_test;

    localparam int UNIT = 128;
    localparam int MAXT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_size = 2'd0;
    logic       irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = 8'h00;
    logic       host_busy, tx_valid, tx_last, stat_done, stat_excess, irq;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       tx_collision = 1'b0;
    logic       backoff_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int lens [16];

    always #10 clk = ~clk;

    pktbuf_tx_ctrl #(.UNIT(UNIT), .MAX_TRIES(MAXT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .irq_en(irq_en),
        .host_wr_en(wr_en), .host_wr_data(wr_data),
        .host_ctl_wr(ctl_wr), .host_ctl_data(ctl_data),
        .host_busy(host_busy), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .tx_collision(tx_collision),
        .backoff_done(backoff_done), .stat_done(stat_done),
        .stat_excess(stat_excess), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int seed, input int p, input int i);
        return 8'(seed + p * 37 + i * 5 + (i >> 3));
    endfunction

    task automatic do_reset(input logic [1:0] sz);
        rst_n = 1'b0;
        cfg_size = sz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_chain(input int seed, input int npk, input logic [4:0] garb);
        for (int p = 0; p < npk; p++) begin
            wr(8'(lens[p]));
            wr({garb, 3'(lens[p] >> 8)});
            for (int i = 0; i < lens[p]; i++) wr(pbyte(seed, p, i));
        end
    endtask

    task automatic start(input int n);
        ctl_wr = 1'b1;
        ctl_data = {1'b1, 7'(n)};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 20 && !tx_valid; k++) @(negedge clk);
    endtask

    task automatic receive(input int seed, input int npk, input int cpk, input int cidx,
                           input int ncoll, input int rmode, input string req);
        int pk = 0, idx = 0, coll = 0, cyc = 0, bo = 0;
        bit wait_bo = 0;
        while (pk < npk && cyc < 30000) begin
            while (pk < npk && lens[pk] == 0) pk++;
            if (pk >= npk) break;
            tx_ready = 1'b0;
            tx_collision = 1'b0;
            backoff_done = 1'b0;
            if (wait_bo) begin
                bo++;
                if (bo == 3) begin
                    backoff_done = 1'b1;
                    wait_bo = 0;
                end
            end else if (tx_valid) begin
                if (pk == cpk && idx == cidx && coll < ncoll) begin
                    tx_collision = 1'b1;
                    coll++;
                    idx = 0;
                    if (coll == MAXT) pk++;
                    else begin
                        wait_bo = 1;
                        bo = 0;
                    end
                end else if (rmode == 0 || (cyc % 3) != 0) begin
                    tx_ready = 1'b1;
                    chk(tx_data == pbyte(seed, pk, idx), req, tx_data, pbyte(seed, pk, idx));
                    chk(tx_last == (idx == lens[pk] - 1), "R8 last flag", tx_last, idx == lens[pk] - 1);
                    idx++;
                    if (idx == lens[pk]) begin
                        pk++;
                        idx = 0;
                    end
                end
            end
            cyc++;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        tx_collision = 1'b0;
        backoff_done = 1'b0;
        chk(pk >= npk, "R8 all frames streamed", pk, npk);
    endtask

    task automatic finish_chain(input bit exp_excess);
        for (int k = 0; k < 20 && host_busy; k++) @(negedge clk);
        chk(!host_busy, "R11 back to idle", host_busy, 0);
        chk(stat_done == 1'b1, "R11 done status", stat_done, 1);
        chk(irq == irq_en, "R11 irq gating", irq, irq_en);
        chk(stat_excess == exp_excess, "R10 excess status", stat_excess, exp_excess);
        chk(!tx_valid, "R7 R8 no extra bytes", tx_valid, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset(2'd1);
        // R1 reset state
        chk(!host_busy && !tx_valid, "R1 idle after reset", host_busy, 0);
        chk(!stat_done && !stat_excess && !irq, "R1 status after reset", stat_done, 0);

        // R4 control writes that must be ignored
        ctl_wr = 1'b1; ctl_data = 8'h03; @(negedge clk); ctl_wr = 1'b0;
        @(negedge clk);
        chk(!host_busy, "R4 start bit clear ignored", host_busy, 0);
        ctl_wr = 1'b1; ctl_data = 8'h80; @(negedge clk); ctl_wr = 1'b0;
        @(negedge clk);
        chk(!host_busy, "R4 zero count ignored", host_busy, 0);

        // R3 R5 R8 sweep over all layouts, two chains each
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m));
            irq_en = m[0];
            for (int r = 0; r < 2; r++) begin
                int bsz = UNIT << ((m == 3) ? 2 : (m == 2) ? 1 : 0);
                int npk = 2 + m;
                int lim = bsz / npk - 2;
                for (int p = 0; p < npk; p++) lens[p] = 1 + (p * 11 + m * 3 + r * 7) % lim;
                load_chain(m * 16 + r, npk, 5'(m * 7 + r));
                start(npk);
                chk(stat_done == 1'b0, "R11 status cleared on start", stat_done, 0);
                receive(m * 16 + r, npk, 99, 0, 0, r, "R3 R8 frame data");
                finish_chain(1'b0);
            end
        end

        // R7 long frame using length bits 10:8 and garbage upper bits
        do_reset(2'd3);
        lens[0] = 300; lens[1] = 1;
        load_chain(55, 2, 5'b10110);
        start(2);
        receive(55, 2, 99, 0, 0, 1, "R7 eleven-bit length");
        finish_chain(1'b0);

        // R7 zero-length frame skipped
        do_reset(2'd1);
        lens[0] = 5; lens[1] = 0; lens[2] = 3;
        load_chain(66, 3, 5'b11111);
        start(3);
        receive(66, 3, 99, 0, 0, 0, "R7 zero length skip");
        finish_chain(1'b0);

        // R9 collisions below the cap
        do_reset(2'd2);
        irq_en = 1'b1;
        lens[0] = 20; lens[1] = 30;
        load_chain(77, 2, 5'd0);
        start(2);
        receive(77, 2, 0, 4, MAXT - 1, 1, "R9 replay after collision");
        finish_chain(1'b0);

        // R10 collision cap skips a frame
        lens[0] = 10; lens[1] = 12; lens[2] = 6;
        load_chain(88, 3, 5'd0);
        start(3);
        chk(stat_done == 1'b0, "R11 status cleared on start", stat_done, 0);
        receive(88, 3, 1, 2, MAXT, 0, "R10 chain after skip");
        finish_chain(1'b1);

        // R6 single-bank lockout while busy
        do_reset(2'd0);
        lens[0] = 40;
        load_chain(101, 1, 5'd0);
        start(1);
        wait_valid();
        chk(host_busy == 1'b1, "R6 busy while sending", host_busy, 1);
        for (int k = 0; k < 10; k++) wr(8'hEE);
        receive(101, 1, 0, 20, 1, 0, "R6 refused writes leave data");
        finish_chain(1'b0);

        // R2 writes past the end of the bank are dropped
        lens[0] = 100;
        load_chain(111, 1, 5'd0);
        for (int k = 0; k < 40; k++) wr(8'h55);
        start(1);
        receive(111, 1, 99, 0, 0, 0, "R2 no wrap past bank end");
        finish_chain(1'b0);

        // R5 R4 loading the other bank while one is sent; start while busy ignored
        do_reset(2'd1);
        lens[0] = 30; lens[1] = 20;
        load_chain(121, 2, 5'd0);
        start(2);
        wait_valid();
        chk(host_busy == 1'b1, "R5 busy during send", host_busy, 1);
        lens[0] = 25; lens[1] = 25;
        load_chain(122, 2, 5'd0);
        start(1);
        lens[0] = 30; lens[1] = 20;
        receive(121, 2, 99, 0, 0, 1, "R5 first bank intact");
        finish_chain(1'b0);
        repeat (5) @(negedge clk);
        chk(!host_busy, "R4 start while busy ignored", host_busy, 0);
        lens[0] = 25; lens[1] = 25;
        start(2);
        receive(122, 2, 99, 0, 0, 0, "R5 second bank data");
        finish_chain(1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule